// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

The block decides whether a port I/O access of 1, 2 or 4 bytes may go ahead. The decision uses the permission bitmap held in the current task-state segment. The caller presents the task-register descriptor (present flag, type nibble, linear base, byte limit), the port number and the access width, all in one cycle together with a request strobe.

The block first checks that the descriptor names a usable segment. It then fetches the bitmap pointer from the segment, derives the byte that holds the first port's permission bit, and fetches a 16-bit window starting at that byte. A multi-byte access whose bits run across a byte boundary is therefore judged on every bit it covers. Both fetches go through a simple request/valid read port that returns 16 bits, little-endian.

The verdict appears on a one-cycle `done` strobe. It is either allow, or a general-protection fault (vector 13) with error code zero. The verdict stays on `allow`/`fault` until the next request is accepted.

Top module: `io_perm_check`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_rd_req`, `done`, `allow` and `fault` are all 0 and `fault_vector` is 0.
- R2: If the descriptor is not present, or its type nibble is not 9, or its limit is below 103, the verdict is a fault and no memory read is issued.
- R3: The first read is at `tss_base + 0x66`; its 16-bit little-endian value (byte at the lower address in bits 7:0) is the bitmap pointer.
- R4: The bitmap byte offset is the pointer plus `req_port >> 3`, and the second read is at `tss_base` plus that offset.
- R5: If the offset plus 1 exceeds the limit, the verdict is a fault and no second read is issued; an offset exactly one below the limit is still read.
- R6: The second read's word is shifted right by `req_port[2:0]`. The access is allowed only when its low `req_size` bits are all zero, so bits from the following byte count for an access that straddles a byte boundary.
- R7: A fault sets `fault_vector` to 13 and `fault_err` to 0; an allow leaves `fault_vector` at 0.
- R8: While a read waits for `mem_rd_valid`, `mem_rd_req` stays high and `mem_rd_addr` stays constant; any response latency gives the same verdict.
- R9: A request strobe that arrives while `busy` is high is ignored: it changes neither the reads nor the verdict, and it produces no further `done`.
- R10: Each accepted request produces exactly one single-cycle `done`, with exactly one of `allow` and `fault` high.
- R11: Offsets are formed in 32 bits, so a large pointer plus a high port number does not wrap. It is caught by the limit check of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a check; accepted only when idle |
| req_port | input | 16 | Port number of the access |
| req_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| tss_present | input | 1 | Descriptor present flag |
| tss_type | input | 4 | Descriptor type nibble |
| tss_base | input | 32 | Segment linear base |
| tss_limit | input | 32 | Segment byte limit |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 16 | Read data, little-endian |
| busy | output | 1 | A check is in progress |
| done | output | 1 | Verdict strobe, one cycle |
| allow | output | 1 | Access permitted (held until next request) |
| fault | output | 1 | General-protection fault (held until next request) |
| fault_vector | output | 8 | 13 on fault, else 0 |
| fault_err | output | 16 | Error code of the fault, always 0 |

## Verification
The awkward cases are those whose outcome hinges on one bit position or one byte of limit. One is a limit exactly at offset plus 1 against one byte lower. Another is a pointer near 0xFFFF combined with a port near 0xFFFF, which wraps only in narrow arithmetic. A third is a denied bit that sits in the byte after the addressed one. The bench places the pointer word and individual permission bits in its own segment image, then picks ports and limits that land on each of these edges. It also stretches the read latency, so that a second request strobe can be injected while the block waits on memory.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int ADDR_W  = 32;
  localparam int PORT_W  = 16;
  localparam int WORD_W  = 16;
  localparam int SIZE_W  = 3;
  localparam int SHIFT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_MAP  = 2'd2,
    ST_DONE = 2'd3
  } iop_state_e;

  // Byte offset of the permission byte inside the segment, widened first.
  function automatic logic [ADDR_W-1:0] map_offset(input logic [WORD_W-1:0] ptr,
                                                   input logic [PORT_W-1:0] port);
    return ADDR_W'(ptr) + ADDR_W'(port >> SHIFT_W);
  endfunction

  // Two bytes are fetched, so the byte after the offset must be in range too.
  function automatic logic past_limit(input logic [ADDR_W-1:0] off,
                                      input logic [ADDR_W-1:0] lim);
    return ({1'b0, off} + (ADDR_W+1)'(1)) > {1'b0, lim};
  endfunction

  function automatic logic bits_clear(input logic [WORD_W-1:0] word,
                                      input logic [SHIFT_W-1:0] sh,
                                      input logic [SIZE_W-1:0] sz);
    logic [WORD_W-1:0] m;
    m = (WORD_W'(1) << sz) - WORD_W'(1);
    return ((word >> sh) & m) == '0;
  endfunction
endpackage

// File: rtl/iop_desc_check.sv
module iop_desc_check #(
  parameter int ADDR_W    = 32,
  parameter int TYPE_OK   = 9,
  parameter int MIN_LIMIT = 103
) (
  input  logic              present,
  input  logic [3:0]        seg_type,
  input  logic [ADDR_W-1:0] limit,
  output logic              ok
);
  always_comb begin
    ok = present && (seg_type == 4'(TYPE_OK)) && (limit >= ADDR_W'(MIN_LIMIT));
  end
endmodule

// File: rtl/iop_map_window.sv
module iop_map_window
  import iop_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [SIZE_W-1:0]  size,
  output logic               clear
);
  always_comb clear = bits_clear(word, shift, size);
endmodule

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
#(
  parameter int PTR_OFF = 'h66
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [PORT_W-1:0]  req_port,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic [ADDR_W-1:0]  tss_base,
  input  logic [ADDR_W-1:0]  tss_limit,
  input  logic               desc_ok,
  input  logic               mem_rd_valid,
  input  logic [WORD_W-1:0]  mem_rd_data,
  input  logic               map_clear,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [SIZE_W-1:0]  size_q,
  output logic               accept,
  output logic               limit_fail,
  output logic               busy,
  output logic               done,
  output logic               allow,
  output logic               fault
);
  iop_state_e        state;
  logic [PORT_W-1:0] port_q;
  logic [ADDR_W-1:0] base_q, limit_q, off_q, off_d;

  always_comb begin
    accept     = req_valid && (state == ST_IDLE);
    off_d      = map_offset(mem_rd_data, port_q);
    limit_fail = (state == ST_PTR) && mem_rd_valid && past_limit(off_d, limit_q);
    busy       = (state != ST_IDLE);
    done       = (state == ST_DONE);
    mem_rd_req = (state == ST_PTR) || (state == ST_MAP);
    mem_rd_addr = (state == ST_MAP) ? (base_q + off_q) : (base_q + ADDR_W'(PTR_OFF));
    shift_q    = port_q[SHIFT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      port_q  <= '0;
      size_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
      off_q   <= '0;
      allow   <= 1'b0;
      fault   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          port_q  <= req_port;
          size_q  <= req_size;
          base_q  <= tss_base;
          limit_q <= tss_limit;
          allow   <= 1'b0;
          fault   <= !desc_ok;
          state   <= desc_ok ? ST_PTR : ST_DONE;
        end
        ST_PTR: if (mem_rd_valid) begin
          if (limit_fail) begin
            fault <= 1'b1;
            state <= ST_DONE;
          end else begin
            off_q <= off_d;
            state <= ST_MAP;
          end
        end
        ST_MAP: if (mem_rd_valid) begin
          allow <= map_clear;
          fault <= !map_clear;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import iop_pkg::*;
#(
  parameter int PTR_OFF   = 'h66,
  parameter int TYPE_OK   = 9,
  parameter int MIN_LIMIT = 103,
  parameter int GP_VECTOR = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [PORT_W-1:0]     req_port,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic                  tss_present,
  input  logic [3:0]            tss_type,
  input  logic [ADDR_W-1:0]     tss_base,
  input  logic [ADDR_W-1:0]     tss_limit,
  output logic                  mem_rd_req,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [WORD_W-1:0]     mem_rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  allow,
  output logic                  fault,
  output logic [7:0]            fault_vector,
  output logic [15:0]           fault_err
);
  logic               desc_ok, map_clear, accept, limit_fail;
  logic [SHIFT_W-1:0] shift_q;
  logic [SIZE_W-1:0]  size_q;

  iop_desc_check #(.ADDR_W(ADDR_W), .TYPE_OK(TYPE_OK), .MIN_LIMIT(MIN_LIMIT)) u_desc (
    .present(tss_present), .seg_type(tss_type), .limit(tss_limit), .ok(desc_ok)
  );

  iop_map_window u_win (
    .word(mem_rd_data), .shift(shift_q), .size(size_q), .clear(map_clear)
  );

  iop_seq #(.PTR_OFF(PTR_OFF)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .tss_base(tss_base), .tss_limit(tss_limit),
    .desc_ok(desc_ok), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .map_clear(map_clear), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .shift_q(shift_q), .size_q(size_q), .accept(accept), .limit_fail(limit_fail),
    .busy(busy), .done(done), .allow(allow), .fault(fault)
  );

  always_comb begin
    fault_vector = fault ? 8'(GP_VECTOR) : 8'd0;
    fault_err    = 16'd0;
  end
endmodule

module iop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd_req,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        done,
  input logic        allow,
  input logic        fault,
  input logic        accept,
  input logic        desc_ok,
  input logic        limit_fail
);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));
  // R10
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (allow ^ fault));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  bad_desc_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !desc_ok |=> !mem_rd_req && done && fault);
  // R5
  limit_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_fail |=> !mem_rd_req && done && fault);
endmodule

bind io_perm_check iop_chk u_iop_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
  .mem_rd_addr(mem_rd_addr), .done(done), .allow(allow), .fault(fault),
  .accept(accept), .desc_ok(desc_ok), .limit_fail(limit_fail)
);

// File: tb/io_perm_check_tb.sv
module io_perm_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TSS_BASE = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_port = '0;
  logic [2:0]  req_size = 3'd1;
  logic tss_present = 1'b0;
  logic [3:0]  tss_type = '0;
  logic [31:0] tss_base = TSS_BASE, tss_limit = '0;
  logic mem_rd_req, busy, done, allow, fault;
  logic [31:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic [7:0]  fault_vector;
  logic [15:0] fault_err;

  int checks = 0, errors = 0;
  int rd_count = 0, lat = 0, wait_cnt = 0;
  logic [31:0] addr_log [0:3];
  logic [7:0]  tmem [0:1023];
  logic [15:0] cur_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_perm_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .tss_present(tss_present), .tss_type(tss_type),
    .tss_base(tss_base), .tss_limit(tss_limit), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .allow(allow), .fault(fault),
    .fault_vector(fault_vector), .fault_err(fault_err)
  );

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    logic [31:0] i;
    i = a - TSS_BASE;
    return (a >= TSS_BASE && i < 32'd1024) ? tmem[i[9:0]] : 8'hFF;
  endfunction

  // memory responder with programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      else if (mem_rd_req) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          mem_rd_valid = 1'b1;
          mem_rd_data = {rd_byte(mem_rd_addr + 32'd1), rd_byte(mem_rd_addr)};
          if (rd_count < 4) addr_log[rd_count] = mem_rd_addr;
          rd_count++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_map(input logic [15:0] ptr);
    for (int i = 0; i < 1024; i++) tmem[i] = 8'h00;
    cur_ptr = ptr;
    tmem['h66] = ptr[7:0];
    tmem['h67] = ptr[15:8];
  endtask

  task automatic deny_port(input logic [15:0] p);
    int idx;
    idx = int'(cur_ptr) + int'(p >> 3);
    if (idx < 1024) tmem[idx] = tmem[idx] | (8'd1 << p[2:0]);
  endtask

  task automatic expect_access(input string tag, input bit pres, input logic [3:0] typ,
                               input logic [31:0] lim, input logic [15:0] port,
                               input logic [2:0] sz, input bit exp_allow,
                               input int exp_reads, input bit poke);
    int n;
    bit seen;
    logic a, f;
    logic [7:0] v;
    logic [15:0] e;
    @(negedge clk);
    rd_count = 0;
    tss_present = pres; tss_type = typ; tss_limit = lim;
    req_port = port; req_size = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R9: strobe while busy, with a descriptor that would fault
      chk(busy == 1'b1, {tag, " R9 busy during check"}, 32'(busy), 1);
      req_valid = 1'b1; tss_present = 1'b0; req_port = 16'h0000;
      @(negedge clk);
      req_valid = 1'b0; tss_present = pres; req_port = port;
    end
    seen = 0; n = 0; a = 0; f = 0; v = 0; e = 0;
    while (!seen && n < 60) begin
      if (done) begin seen = 1; a = allow; f = fault; v = fault_vector; e = fault_err; end
      else begin @(negedge clk); n++; end
    end
    chk(seen, {tag, " R10 done seen"}, 32'(seen), 1);
    chk(a == exp_allow && f == !exp_allow, {tag, " R6 verdict allow"}, 32'(a), 32'(exp_allow));
    chk(v == (exp_allow ? 8'd0 : 8'd13) && e == 16'd0, {tag, " R7 vector"}, 32'(v),
        exp_allow ? 0 : 13);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done && !mem_rd_req, {tag, " R10 single done"}, 32'(done), 0);
    end
    chk(rd_count == exp_reads, {tag, " R2 R5 read count"}, 32'(rd_count), 32'(exp_reads));
    if (exp_reads >= 1)
      chk(addr_log[0] == TSS_BASE + 32'h66, {tag, " R3 pointer addr"}, addr_log[0], TSS_BASE + 32'h66);
    if (exp_reads >= 2)
      chk(addr_log[1] == TSS_BASE + 32'(cur_ptr) + 32'(port >> 3), {tag, " R4 map addr"},
          addr_log[1], TSS_BASE + 32'(cur_ptr) + 32'(port >> 3));
  endtask

  task automatic t_reset();
    // R1
    chk(!busy && !mem_rd_req && !done && !allow && !fault && fault_vector == 0,
        "R1 idle after reset", {busy, mem_rd_req, done, allow, fault}, 0);
  endtask

  task automatic t_bad_desc();
    clear_map(16'h0068);
    expect_access("R2 not present", 1'b0, 4'd9, 32'h2000, 16'h10, 3'd1, 1'b0, 0, 1'b0);
    expect_access("R2 wrong type", 1'b1, 4'd11, 32'h2000, 16'h10, 3'd1, 1'b0, 0, 1'b0);
    expect_access("R2 limit 102", 1'b1, 4'd9, 32'd102, 16'h0, 3'd1, 1'b0, 0, 1'b0);
    expect_access("R2 limit 103 ok", 1'b1, 4'd9, 32'd103, 16'h0, 3'd1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_bits();
    clear_map(16'h0068);
    deny_port(16'h23);
    expect_access("R6 clear port", 1'b1, 4'd9, 32'h2000, 16'h10, 3'd1, 1'b1, 2, 1'b0);
    expect_access("R6 denied bit", 1'b1, 4'd9, 32'h2000, 16'h23, 3'd1, 1'b0, 2, 1'b0);
    expect_access("R6 neighbour", 1'b1, 4'd9, 32'h2000, 16'h22, 3'd1, 1'b1, 2, 1'b0);
    expect_access("R6 dword covers", 1'b1, 4'd9, 32'h2000, 16'h20, 3'd4, 1'b0, 2, 1'b0);
    expect_access("R6 dword above", 1'b1, 4'd9, 32'h2000, 16'h24, 3'd4, 1'b1, 2, 1'b0);
  endtask

  task automatic t_straddle();
    clear_map(16'h0068);
    deny_port(16'h28);
    expect_access("R6 word before edge", 1'b1, 4'd9, 32'h2000, 16'h26, 3'd2, 1'b1, 2, 1'b0);
    expect_access("R6 straddle dword", 1'b1, 4'd9, 32'h2000, 16'h26, 3'd4, 1'b0, 2, 1'b0);
    expect_access("R6 straddle word", 1'b1, 4'd9, 32'h2000, 16'h27, 3'd2, 1'b0, 2, 1'b0);
  endtask

  task automatic t_limit();
    clear_map(16'h0068);
    // offset 0x6F: +1 equals limit, still read
    expect_access("R5 at limit", 1'b1, 4'd9, 32'h70, 16'h38, 3'd1, 1'b1, 2, 1'b0);
    // offset 0x70: one past
    expect_access("R5 past limit", 1'b1, 4'd9, 32'h70, 16'h40, 3'd1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_wrap();
    clear_map(16'hFFFF);
    expect_access("R11 no wrap", 1'b1, 4'd9, 32'h2100, 16'hFFF8, 3'd1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_latency();
    clear_map(16'h0068);
    deny_port(16'h31);
    lat = 3;
    expect_access("R8 slow allow", 1'b1, 4'd9, 32'h2000, 16'h32, 3'd2, 1'b1, 2, 1'b0);
    expect_access("R8 slow deny", 1'b1, 4'd9, 32'h2000, 16'h30, 3'd2, 1'b0, 2, 1'b0);
    lat = 0;
  endtask

  task automatic t_busy();
    clear_map(16'h0068);
    lat = 4;
    expect_access("R9 ignored strobe", 1'b1, 4'd9, 32'h2000, 16'h10, 3'd1, 1'b1, 2, 1'b1);
    lat = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_desc();
    t_bits();
    t_straddle();
    t_limit();
    t_wrap();
    t_latency();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule